// File: doc/BRIEF.md
# PHY Delay Register Mailbox Bridge

This block lets host software reach a small bank of 8-bit PHY delay settings through one 32-bit mailbox register, not through a separate memory-mapped location per setting. Software first loads a target address and a write byte into the register. It then raises a write or a read request bit and polls an acknowledge flag. When the flag is seen, software drops the request. The bridge converts each request into a single-cycle strobe on an internal PHY-side bus and waits for the bank to signal completion. It then raises the acknowledge flag and keeps it raised until software closes the four-phase handshake.

A behavioural bank model is part of the block, so it can be tested on its own. Twelve addresses are populated: 0x00 to 0x08 and 0x0B to 0x0D. Every other address in the 6-bit space is empty. The bank takes a fixed, parameterised number of cycles to complete each access.

The controller is a four-state machine:
- `S_IDLE` waits for a request and, on leaving, snapshots the address, the data and the kind of operation.
- `S_ISSUE` drives one strobe.
- `S_WAIT` waits for the bank's completion pulse.
- `S_HOLD` presents the acknowledge.

The transitions are:
- IDLE→ISSUE when either request bit is set.
- ISSUE→WAIT unconditionally.
- WAIT→HOLD on the completion pulse.
- HOLD→IDLE once both request bits are clear.

Top module: `phyport_bridge`

## Requirements
- R1: The mailbox register layout is as follows. Bits [5:0] hold the PHY address and bits [15:8] hold the write byte; both read back as written. Bit 24 is the write request and bit 25 is the read request; both read back as written. Bits [23:16] hold the last byte read from the PHY. Bit 26 is the acknowledge flag. Bits [31:27] and [7:6] read as zero.
- R2: A write handshake stores the write byte in the bank entry selected by the address field, as long as that address is populated.
- R3: A read handshake places the selected entry's byte in bits [23:16]. The byte is valid when the acknowledge flag reads 1.
- R4: The acknowledge flag rises only in the cycle after the bank signals completion. It stays at 1 for as long as either request bit remains set.
- R5: Once both request bits are cleared, the acknowledge flag returns to 0 within one clock cycle.
- R6: While an operation is in flight or the acknowledge flag is 1, new requests and changes to the address or data fields do not start another PHY access. The operation in flight uses the address and data that were present when it started.
- R7: If both request bits are set together, a write is performed and bits [23:16] are left unchanged.
- R8: Writes to unpopulated addresses (0x09, 0x0A and 0x0E to 0x3F) change nothing. Reads from those addresses return 0x00.
- R9: Host writes to bits [26] and [23:16] are ignored; those bits are driven only by the bridge.
- R10: After reset the register reads 0x0000_0000 and every bank entry holds 0x00.
- R11: Each PHY access consists of exactly one single-cycle strobe, write or read, never both. No strobe is issued while the acknowledge flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write enable |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read-back value |

## Verification
The assertions check the handshake on every cycle:
- the acknowledge flag rises only after a completion pulse, holds while a request is set, and drops in the cycle after both requests clear;
- strobes are single-cycle and never overlap, never occur under acknowledge, and never read while a write request was pending;
- the read-data field moves only when a read completes.

Only the bench's scenarios can show the following:
- which bank entry actually changed;
- that an unpopulated address reads zero;
- that a request raised while the acknowledge flag is high leaves the bank untouched;
- that the fields snapshotted at the start of an operation are the ones used.

// File: rtl/phyport_pkg.sv
package phyport_pkg;

    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 8;
    localparam int REG_W     = 32;
    localparam int ADDR_LSB  = 0;
    localparam int WDATA_LSB = 8;
    localparam int RDATA_LSB = 16;
    localparam int WR_BIT    = 24;
    localparam int RD_BIT    = 25;
    localparam int ACK_BIT   = 26;
    localparam int BANK_DEPTH = 1 << ADDR_W;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_HOLD  = 2'd3
    } port_state_e;

    // Populated delay slots: 0x00..0x08 and 0x0B..0x0D
    function automatic logic slot_mapped(input logic [ADDR_W-1:0] a);
        return (a <= ADDR_W'(8)) || ((a >= ADDR_W'(11)) && (a <= ADDR_W'(13)));
    endfunction

endpackage

// File: rtl/phyport_hostreg.sv
module phyport_hostreg
    import phyport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    output logic [ADDR_W-1:0] addr_f,
    output logic [DATA_W-1:0] wdat_f,
    output logic              wr_req,
    output logic              rd_req
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_f <= '0;
            wdat_f <= '0;
            wr_req <= 1'b0;
            rd_req <= 1'b0;
        end else if (we) begin
            addr_f <= wdata[ADDR_LSB +: ADDR_W];
            wdat_f <= wdata[WDATA_LSB +: DATA_W];
            wr_req <= wdata[WR_BIT];
            rd_req <= wdata[RD_BIT];
        end
    end

endmodule

// File: rtl/phyport_ctrl.sv
module phyport_ctrl
    import phyport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] addr_f,
    input  logic [DATA_W-1:0] wdat_f,
    input  logic              phy_done,
    input  logic [DATA_W-1:0] phy_rdata,
    output logic              phy_wstb,
    output logic              phy_rstb,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [DATA_W-1:0] phy_wdata,
    output logic              ack,
    output logic              rd_cpl,
    output logic [DATA_W-1:0] rdata_f
);

    port_state_e state, state_nxt;
    logic        op_wr;
    logic        any_req;

    assign any_req = wr_req | rd_req;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // next-state decode
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (any_req)  state_nxt = S_ISSUE;
            S_ISSUE:               state_nxt = S_WAIT;
            S_WAIT:  if (phy_done) state_nxt = S_HOLD;
            S_HOLD:  if (!any_req) state_nxt = S_IDLE;
            default:               state_nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        phy_wstb = 1'b0;
        phy_rstb = 1'b0;
        ack      = 1'b0;
        rd_cpl   = 1'b0;
        unique case (state)
            S_IDLE:  ;
            S_ISSUE: begin
                phy_wstb = op_wr;
                phy_rstb = !op_wr;
            end
            S_WAIT:  rd_cpl = phy_done && !op_wr;
            S_HOLD:  ack = 1'b1;
            default: ;
        endcase
    end

    // operation snapshot and read-data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_wr     <= 1'b0;
            phy_addr  <= '0;
            phy_wdata <= '0;
            rdata_f   <= '0;
        end else begin
            if (state == S_IDLE && any_req) begin
                op_wr     <= wr_req;
                phy_addr  <= addr_f;
                phy_wdata <= wdat_f;
            end
            if (rd_cpl) rdata_f <= phy_rdata;
        end
    end

endmodule

// File: rtl/phyport_bank.sv
module phyport_bank
    import phyport_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wstb,
    input  logic              rstb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    localparam int LAT_EFF = (LATENCY < 1) ? 1 : LATENCY;
    localparam int CNT_W   = $clog2(LAT_EFF + 1);

    logic [DATA_W-1:0] mem [BANK_DEPTH];
    logic              busy;
    logic              cur_wr;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] cur_a;
    logic [DATA_W-1:0] cur_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BANK_DEPTH; i++) mem[i] <= '0;
            busy   <= 1'b0;
            cur_wr <= 1'b0;
            cnt    <= '0;
            cur_a  <= '0;
            cur_d  <= '0;
            done   <= 1'b0;
            rdata  <= '0;
        end else begin
            done <= 1'b0;
            if (wstb || rstb) begin
                busy   <= 1'b1;
                cur_wr <= wstb;
                cnt    <= CNT_W'(LAT_EFF - 1);
                cur_a  <= addr;
                cur_d  <= wdata;
            end else if (busy) begin
                if (cnt == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    if (cur_wr && slot_mapped(cur_a)) mem[cur_a] <= cur_d;
                    rdata <= (!cur_wr && slot_mapped(cur_a)) ? mem[cur_a] : '0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/phyport_bridge.sv
module phyport_bridge
    import phyport_pkg::*;
#(
    parameter int BANK_LAT = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata
);

    logic [ADDR_W-1:0] addr_f;
    logic [DATA_W-1:0] wdat_f;
    logic              wr_req, rd_req;
    logic              phy_wstb, phy_rstb, phy_done;
    logic [ADDR_W-1:0] phy_addr;
    logic [DATA_W-1:0] phy_wdata, phy_rdata;
    logic              ack, rd_cpl;
    logic [DATA_W-1:0] rdata_f;
    logic              unused_wbits;

    assign unused_wbits = ^{host_wdata[31:26], host_wdata[23:16], host_wdata[7:6]};

    phyport_hostreg u_hostreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (host_we),
        .wdata  (host_wdata),
        .addr_f (addr_f),
        .wdat_f (wdat_f),
        .wr_req (wr_req),
        .rd_req (rd_req)
    );

    phyport_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .rd_req    (rd_req),
        .addr_f    (addr_f),
        .wdat_f    (wdat_f),
        .phy_done  (phy_done),
        .phy_rdata (phy_rdata),
        .phy_wstb  (phy_wstb),
        .phy_rstb  (phy_rstb),
        .phy_addr  (phy_addr),
        .phy_wdata (phy_wdata),
        .ack       (ack),
        .rd_cpl    (rd_cpl),
        .rdata_f   (rdata_f)
    );

    phyport_bank #(.LATENCY(BANK_LAT)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wstb  (phy_wstb),
        .rstb  (phy_rstb),
        .addr  (phy_addr),
        .wdata (phy_wdata),
        .done  (phy_done),
        .rdata (phy_rdata)
    );

    always_comb begin
        host_rdata = '0;
        host_rdata[ADDR_LSB  +: ADDR_W] = addr_f;
        host_rdata[WDATA_LSB +: DATA_W] = wdat_f;
        host_rdata[RDATA_LSB +: DATA_W] = rdata_f;
        host_rdata[WR_BIT]  = wr_req;
        host_rdata[RD_BIT]  = rd_req;
        host_rdata[ACK_BIT] = ack;
    end

endmodule

// File: rtl/phyport_bridge_chk.sv
module phyport_bridge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ack,
    input logic       wr_req,
    input logic       rd_req,
    input logic       phy_wstb,
    input logic       phy_rstb,
    input logic       phy_done,
    input logic       rd_cpl,
    input logic [7:0] rdata_f
);

    // R4: acknowledge rises only right after the bank's completion pulse
    a_r4_ack_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(phy_done));

    // R4: acknowledge holds while a request bit is set
    a_r4_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (wr_req || rd_req)) |=> ack);

    // R5: acknowledge drops one cycle after both requests clear
    a_r5_ack_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wr_req && !rd_req) |=> !ack);

    // R11: never both strobes
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(phy_wstb && phy_rstb));

    // R11: strobes last one cycle
    a_r11_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_wstb || phy_rstb) |=> !(phy_wstb || phy_rstb));

    // R6: no PHY access starts while acknowledge is high
    a_r6_no_strobe_under_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_wstb || phy_rstb) |-> !ack);

    // R7: a read strobe never follows a pending write request
    a_r7_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rstb |-> !$past(wr_req));

    // R9: read-data field changes only on read completion
    a_r9_rdata_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cpl |=> $stable(rdata_f));

endmodule

bind phyport_bridge phyport_bridge_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .wr_req   (wr_req),
    .rd_req   (rd_req),
    .phy_wstb (phy_wstb),
    .phy_rstb (phy_rstb),
    .phy_done (phy_done),
    .rd_cpl   (rd_cpl),
    .rdata_f  (rdata_f)
);

// File: tb/phyport_bridge_bench.sv
module phyport_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #2ns clk = ~clk;

    phyport_bridge u_phyport_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    // vector: {is_wr, unpopulated, addr[5:0], data[7:0], expected[7:0]}
    localparam int NV = 11;
    localparam logic [23:0] VEC [NV] = '{
        {1'b1, 1'b0, 6'h00, 8'h11, 8'h00},
        {1'b1, 1'b0, 6'h0D, 8'hA5, 8'h00},
        {1'b1, 1'b0, 6'h08, 8'h3C, 8'h00},
        {1'b1, 1'b1, 6'h09, 8'h77, 8'h00},
        {1'b0, 1'b0, 6'h00, 8'h00, 8'h11},
        {1'b0, 1'b0, 6'h0D, 8'h00, 8'hA5},
        {1'b0, 1'b0, 6'h08, 8'h00, 8'h3C},
        {1'b0, 1'b1, 6'h09, 8'h00, 8'h00},
        {1'b1, 1'b1, 6'h3F, 8'hFF, 8'h00},
        {1'b0, 1'b1, 6'h3F, 8'h00, 8'h00},
        {1'b0, 1'b0, 6'h01, 8'h00, 8'h00}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        host_we    = 1'b1;
        host_wdata = v;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic wait_ack(output bit got);
        got = 1'b0;
        for (int i = 0; i < 50 && !got; i++) begin
            if (host_rdata[26]) got = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic run_access(input bit is_wr, input logic [5:0] a, input logic [7:0] d,
                              output logic [7:0] rd, output bit got);
        logic [31:0] base;
        base = {16'h0000, d, 2'b00, a};
        reg_write(base);
        reg_write(base | (is_wr ? 32'h0100_0000 : 32'h0200_0000));
        wait_ack(got);
        rd = host_rdata[23:16];
        reg_write(base);
        @(negedge clk);
    endtask

    initial begin
        #400us;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        bit         got;
        logic [7:0] prev;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(host_rdata == 32'h0, "R10 reset value", host_rdata, 32'h0);

        // R1: fields read back, reserved bits zero
        reg_write(32'hF800_ABC7);
        check(host_rdata == 32'h0000_AB07, "R1 field layout", host_rdata, 32'h0000_AB07);
        reg_write(32'h0);

        for (int k = 0; k < NV; k++) begin
            logic [23:0] v;
            v = VEC[k];
            run_access(v[23], v[21:16], v[15:8], rd, got);
            check(got, "R4 ack seen", {31'h0, got}, 32'h1);
            if (!v[23])
                check(rd == v[7:0], v[22] ? "R8 unpopulated read" : "R3 read data",
                      {24'h0, rd}, {24'h0, v[7:0]});
        end

        // R2: bank write confirmed by later read of 0x0D
        run_access(1'b0, 6'h0D, 8'h00, rd, got);
        check(rd == 8'hA5, "R2 stored byte", {24'h0, rd}, 32'hA5);

        // R9: read-only bits ignored
        prev = host_rdata[23:16];
        reg_write(32'h04FF_0000);
        check(host_rdata[26] == 1'b0 && host_rdata[23:16] == prev, "R9 read-only bits",
              host_rdata, {8'h0, prev, 16'h0});

        // R4/R5: ack holds while request set, falls after clear
        reg_write(32'h0000_4204);
        reg_write(32'h0100_4204);
        wait_ack(got);
        repeat (3) @(negedge clk);
        check(host_rdata[26] == 1'b1, "R4 ack held", host_rdata, 32'h0500_4204);
        reg_write(32'h0000_4204);
        @(negedge clk);
        check(host_rdata[26] == 1'b0, "R5 ack falls", host_rdata, 32'h0000_4204);

        // R7: both request bits -> write, rdata field untouched
        prev = host_rdata[23:16];
        reg_write(32'h0000_9C05);
        reg_write(32'h0300_9C05);
        wait_ack(got);
        check(got && host_rdata[23:16] == prev, "R7 rdata untouched", host_rdata, {8'h07, prev, 16'h9C05});
        reg_write(32'h0000_9C05);
        @(negedge clk);
        run_access(1'b0, 6'h05, 8'h00, rd, got);
        check(rd == 8'h9C, "R7 write performed", {24'h0, rd}, 32'h9C);

        // R6: field changes while busy are ignored
        reg_write(32'h0000_5502);
        reg_write(32'h0100_5502);
        reg_write(32'h0300_6603);
        wait_ack(got);
        reg_write(32'h0000_6603);
        @(negedge clk);
        run_access(1'b0, 6'h02, 8'h00, rd, got);
        check(rd == 8'h55, "R6 snapshot used", {24'h0, rd}, 32'h55);
        run_access(1'b0, 6'h03, 8'h00, rd, got);
        check(rd == 8'h00, "R6 no second access", {24'h0, rd}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule